// File: doc/BRIEF.md
# Bit-Addressable Manipulation Unit

This unit performs single-bit operations on a byte-organised data space. Each bit in that space has a 10-bit bit address. The caller supplies this address in two pieces: two high bits taken from the low end of the operation word, and a fetched address byte. Bit addresses in the lower half select a byte and a bit position in the directly addressed data area. Bit addresses in the upper half are moved onto a separate register window that starts at byte address 0x400.

The unit supports five operations. Set and clear modify the target bit through a read-modify-write of the whole byte. Two carry operations AND the carry flag with the bit or with its inverse; these can only clear the carry, never set it. Jump-if-bit-set-then-clear reports whether the bit was 1 and always writes the bit back as 0.

Each operation takes one read cycle and then one write or result cycle. A busy output is high for both cycles, and requests that arrive while busy is high are dropped. The unit does not compute branch targets, fetch instructions or arbitrate the memory. It assumes a synchronous memory whose read data arrives one cycle after the read strobe.

Top module: `bitop_engine`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `mem_rd`, `mem_wr`, `done` and `branch_taken` are all 0.
- R2: The bit address is `{op_hi, op_lo}`. Below 0x200 it selects byte address (address / 8) and bit position (address mod 8).
- R3: At or above 0x200, 0x200 is subtracted first, and the byte address is 0x400 + (remainder / 8) with bit position (remainder mod 8).
- R4: A request is accepted at a clock edge where `op_valid` is 1 and `busy` is 0. `mem_rd` is then high for the next cycle, and `done` is high for the cycle after that. `busy` is high in both cycles. `mem_addr` holds the mapped byte address in both cycles.
- R5: Set (`op_code` 0) writes back the read byte with the addressed bit forced to 1. All other bits of the byte are unchanged.
- R6: Clear (`op_code` 1) writes back the read byte with the addressed bit forced to 0. All other bits of the byte are unchanged.
- R7: Carry-AND (`op_code` 2) gives `carry_out` = captured `carry_in` AND bit during `done`, and does not write memory.
- R8: Carry-AND-inverted (`op_code` 3) gives `carry_out` = captured `carry_in` AND NOT bit during `done`, and does not write memory.
- R9: Jump-if-set (`op_code` 4) drives `branch_taken` to the read bit value during `done`, and always writes the byte back with that bit cleared.
- R10: A request presented while `busy` is 1 has no effect on memory. Codes 5 to 7 are not accepted: `busy` stays 0.
- R11: `branch_taken` is high only during `done`. For set, clear and jump-if-set, `carry_out` during `done` equals the captured `carry_in`. `mem_wr` is high only during `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 3 | Operation: 0 set, 1 clear, 2 carry-AND, 3 carry-AND-inverted, 4 jump-if-set-then-clear |
| op_hi | input | 2 | Bit address bits [9:8] |
| op_lo | input | 8 | Bit address bits [7:0] |
| carry_in | input | 1 | Carry flag before the operation |
| carry_out | output | 1 | Carry flag result, valid with `done` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result cycle of an operation |
| branch_taken | output | 1 | Jump-if-set found the bit at 1 |
| mem_addr | output | 11 | Byte address |
| mem_rd | output | 1 | Read strobe; data expected next cycle |
| mem_rdata | input | 8 | Read data |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
The bound checker enforces the following on every cycle:
- the read-then-result cycle order;
- that a read only follows an accepted request;
- that writes and `branch_taken` occur only in the result cycle;
- that a written byte differs from the byte read in at most one bit.

The bench scenarios cover the facts a property cannot hold:
- the address mapping for all 1024 bit addresses;
- the exact carry and branch values;
- the exact written byte, including its neighbour bits;
- requests that are dropped while busy, or dropped because the code is unused.

// File: rtl/bitop_pkg.sv
// Shared types for the bit manipulation unit.
// Assumes a 3-bit operation code; codes outside the enum are illegal.
package bitop_pkg;

    typedef enum logic [2:0] {
        OP_SET   = 3'd0,
        OP_CLR   = 3'd1,
        OP_CAND  = 3'd2,
        OP_CANDN = 3'd3,
        OP_JBC   = 3'd4
    } bit_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    // True for codes the unit executes.
    function automatic logic op_is_legal(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/bitop_addr_map.sv
// Bit-address to byte-address mapper.
// Splits a bit address into a byte index and a bit position. Addresses at
// or above WIN_SPLIT are rebased and placed from byte WIN_BASE onwards.
// Assumes DATA_W is a power of two and BYTE_AW > BIT_AW.
module bitop_addr_map #(
    parameter int BIT_AW    = 10,
    parameter int BYTE_AW   = 11,
    parameter int DATA_W    = 8,
    parameter int WIN_SPLIT = 512,
    parameter int WIN_BASE  = 1024
) (
    input  logic [BIT_AW-1:0]          bit_addr,
    output logic [BYTE_AW-1:0]         byte_addr,
    output logic [$clog2(DATA_W)-1:0]  bit_pos
);
    localparam int POS_W = $clog2(DATA_W);

    logic              in_win;
    logic [BIT_AW-1:0] rel;
    logic [BIT_AW-1:0] idx;

    // Window select and rebasing of the bit address.
    always_comb begin
        in_win = (bit_addr >= BIT_AW'(WIN_SPLIT));
        rel    = in_win ? (bit_addr - BIT_AW'(WIN_SPLIT)) : bit_addr;
        idx    = rel >> POS_W;
    end

    // Byte address and bit position output.
    always_comb begin
        bit_pos   = rel[POS_W-1:0];
        byte_addr = (in_win ? BYTE_AW'(WIN_BASE) : '0) + BYTE_AW'(idx);
    end

endmodule

// File: rtl/bitop_alu.sv
// Bit operation datapath.
// Computes the write-back byte, whether to write, the new carry and the
// branch decision from the byte that was read. Purely combinational.
// Assumes rdata is the byte at the mapped address.
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bit_op_e                    op,
    input  logic [DATA_W-1:0]          rdata,
    input  logic [$clog2(DATA_W)-1:0]  bit_pos,
    input  logic                       carry,
    output logic [DATA_W-1:0]          wdata,
    output logic                       wr_en,
    output logic                       carry_next,
    output logic                       take_branch
);
    logic [DATA_W-1:0] mask;
    logic              cur_bit;

    // Single-bit mask and the current value of the selected bit.
    always_comb begin
        mask    = DATA_W'(1) << bit_pos;
        cur_bit = |(rdata & mask);
    end

    // Per-operation result selection.
    always_comb begin
        wdata       = rdata;
        wr_en       = 1'b0;
        carry_next  = carry;
        take_branch = 1'b0;
        case (op)
            OP_SET: begin
                wdata = rdata | mask;
                wr_en = 1'b1;
            end
            OP_CLR: begin
                wdata = rdata & ~mask;
                wr_en = 1'b1;
            end
            OP_CAND:  carry_next = carry & cur_bit;
            OP_CANDN: carry_next = carry & ~cur_bit;
            OP_JBC: begin
                wdata       = rdata & ~mask;
                wr_en       = 1'b1;
                take_branch = cur_bit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bitop_ctrl.sv
// Sequencer for the bit manipulation unit.
// Captures a legal request while idle, then steps through a read cycle
// and a result/write cycle. Requests seen while busy are dropped.
module bitop_ctrl
    import bitop_pkg::*;
#(
    parameter int BIT_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [BIT_AW-1:0] bit_addr_in,
    input  logic              carry_in,
    output bit_op_e           op_q,
    output logic [BIT_AW-1:0] bit_addr_q,
    output logic              carry_q,
    output logic              in_read,
    output logic              in_write
);
    seq_state_e state;
    logic       accept;

    // Accept only when idle and the code is implemented.
    always_comb accept = op_valid && (state == ST_IDLE) && op_is_legal(op_code);

    // State register: idle -> read -> write -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (accept) state <= ST_READ;
                ST_READ:  state <= ST_WRITE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Request capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_SET;
            bit_addr_q <= '0;
            carry_q    <= 1'b0;
        end else if (accept) begin
            op_q       <= bit_op_e'(op_code);
            bit_addr_q <= bit_addr_in;
            carry_q    <= carry_in;
        end
    end

    // Phase decode.
    always_comb begin
        in_read  = (state == ST_READ);
        in_write = (state == ST_WRITE);
    end

endmodule

// File: rtl/bitop_engine.sv
// Bit-addressable manipulation unit, top level.
// Builds the bit address from op_hi/op_lo, maps it to a byte, and runs one
// read-modify-write (or read-and-test) per accepted request over a
// synchronous byte memory with one cycle of read latency.
module bitop_engine
    import bitop_pkg::*;
#(
    parameter int BIT_AW    = 10,
    parameter int BYTE_AW   = 11,
    parameter int DATA_W    = 8,
    parameter int WIN_SPLIT = 512,
    parameter int WIN_BASE  = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [2:0]         op_code,
    input  logic [1:0]         op_hi,
    input  logic [7:0]         op_lo,
    input  logic               carry_in,
    output logic               carry_out,
    output logic               busy,
    output logic               done,
    output logic               branch_taken,
    output logic [BYTE_AW-1:0] mem_addr,
    output logic               mem_rd,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_wr,
    output logic [DATA_W-1:0]  mem_wdata
);
    localparam int POS_W = $clog2(DATA_W);

    bit_op_e           op_q;
    logic [BIT_AW-1:0] bit_addr_in;
    logic [BIT_AW-1:0] bit_addr_q;
    logic              carry_q;
    logic              in_read;
    logic              in_write;
    logic [POS_W-1:0]  bit_pos;
    logic              alu_wr;
    logic              alu_carry;
    logic              alu_branch;

    // Concatenate the two address pieces.
    always_comb bit_addr_in = BIT_AW'({op_hi, op_lo});

    bitop_ctrl #(.BIT_AW(BIT_AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_code     (op_code),
        .bit_addr_in (bit_addr_in),
        .carry_in    (carry_in),
        .op_q        (op_q),
        .bit_addr_q  (bit_addr_q),
        .carry_q     (carry_q),
        .in_read     (in_read),
        .in_write    (in_write)
    );

    bitop_addr_map #(
        .BIT_AW    (BIT_AW),
        .BYTE_AW   (BYTE_AW),
        .DATA_W    (DATA_W),
        .WIN_SPLIT (WIN_SPLIT),
        .WIN_BASE  (WIN_BASE)
    ) u_map (
        .bit_addr  (bit_addr_q),
        .byte_addr (mem_addr),
        .bit_pos   (bit_pos)
    );

    bitop_alu #(.DATA_W(DATA_W)) u_alu (
        .op          (op_q),
        .rdata       (mem_rdata),
        .bit_pos     (bit_pos),
        .carry       (carry_q),
        .wdata       (mem_wdata),
        .wr_en       (alu_wr),
        .carry_next  (alu_carry),
        .take_branch (alu_branch)
    );

    // Output strobes and results, gated by sequencer phase.
    always_comb begin
        busy         = in_read | in_write;
        done         = in_write;
        mem_rd       = in_read;
        mem_wr       = in_write & alu_wr;
        branch_taken = in_write & alu_branch;
        carry_out    = in_write ? alu_carry : carry_q;
    end

endmodule

// File: rtl/bitop_engine_chk.sv
// Protocol checker for bitop_engine, attached with bind.
// Observes ports only; assumes synchronous active-low reset.
module bitop_engine_chk #(
    parameter int BYTE_AW = 11,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic [2:0]         op_code,
    input logic               busy,
    input logic               done,
    input logic               branch_taken,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic [DATA_W-1:0]  mem_rdata,
    input logic [DATA_W-1:0]  mem_wdata,
    input logic [BYTE_AW-1:0] mem_addr
);
    // R4: a read cycle is followed by the result cycle.
    a_r4_read_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> done);

    // R4: result cycle always follows a read cycle at the same byte.
    a_r4_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_rd) && $stable(mem_addr)));

    // R10: a read only starts after a legal request seen while idle.
    a_r10_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> ($past(op_valid) && !$past(busy) && $past(op_code) <= 3'd4));

    // R11: writes only in the result cycle.
    a_r11_write_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> done);

    // R11: branch only in the result cycle.
    a_r11_branch_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> done);

    // R5/R6/R9: written byte differs from read byte in at most one bit.
    a_r5_single_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($countones(mem_wdata ^ mem_rdata) <= 1));

    // R4: busy covers both cycles of an operation.
    a_r4_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || done) |-> busy);
endmodule

bind bitop_engine bitop_engine_chk #(.BYTE_AW(BYTE_AW), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .busy         (busy),
    .done         (done),
    .branch_taken (branch_taken),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_rdata    (mem_rdata),
    .mem_wdata    (mem_wdata),
    .mem_addr     (mem_addr)
);

// File: tb/bitop_engine_test.sv
// Exhaustive sweep of all bit addresses through every operation, with a
// behavioural byte memory in the bench.
module bitop_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [1:0]  op_hi = 2'd0;
    logic [7:0]  op_lo = 8'd0;
    logic        carry_in = 1'b0;
    logic        carry_out, busy, done, branch_taken, mem_rd, mem_wr;
    logic [10:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata;

    logic [7:0]  mem [0:2047];
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    bitop_engine uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_hi(op_hi), .op_lo(op_lo), .carry_in(carry_in),
        .carry_out(carry_out), .busy(busy), .done(done),
        .branch_taken(branch_taken), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    // Synchronous byte memory, pattern-filled during reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= 8'((i * 37 + 5) & 255);
        end else if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_byte(input int a);
        if (a < 512) return a / 8;
        return 1024 + (a - 512) / 8;
    endfunction

    // Run one operation and check every cycle of it.
    task automatic run_op(input int op, input int a, input bit cin);
        int eb = exp_byte(a);
        int pos = a % 8;
        int pre, post, bitv;
        bit exp_c, exp_br, exp_wr;
        string tag;
        @(negedge clk);
        pre  = int'(mem[eb]);
        bitv = (pre >> pos) & 1;
        op_valid = 1'b1; op_code = 3'(op);
        op_hi = 2'(a >> 8); op_lo = 8'(a & 255); carry_in = cin;
        case (op)
            0: begin post = pre | (1 << pos);  exp_c = cin; exp_br = 0; exp_wr = 1; tag = "R5"; end
            1: begin post = pre & ~(1 << pos); exp_c = cin; exp_br = 0; exp_wr = 1; tag = "R6"; end
            2: begin post = pre; exp_c = cin & bitv[0];  exp_br = 0; exp_wr = 0; tag = "R7"; end
            3: begin post = pre; exp_c = cin & ~bitv[0]; exp_br = 0; exp_wr = 0; tag = "R8"; end
            default: begin post = pre & ~(1 << pos); exp_c = cin; exp_br = bitv[0]; exp_wr = 1; tag = "R9"; end
        endcase
        @(negedge clk);
        op_valid = 1'b0;
        chk(busy && mem_rd, "R4 read phase", {busy, mem_rd}, 3);
        chk(int'(mem_addr) == eb, (a < 512) ? "R2 byte address" : "R3 window address", mem_addr, eb);
        @(negedge clk);
        chk(done && busy, "R4 result phase", {done, busy}, 3);
        chk(mem_wr == exp_wr, {tag, " write strobe"}, mem_wr, exp_wr);
        chk(carry_out == exp_c, {tag, " carry (R11)"}, carry_out, exp_c);
        chk(branch_taken == exp_br, {tag, " branch (R11)"}, branch_taken, exp_br);
        @(negedge clk);
        chk(!busy, "R4 idle after", busy, 0);
        chk(int'(mem[eb]) == post, {tag, " byte content"}, mem[eb], post);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int eb;
        logic [7:0] snap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !mem_rd && !mem_wr && !done && !branch_taken, "R1 reset outputs",
            {busy, mem_rd, mem_wr, done, branch_taken}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);

        // Exhaustive sweep over every bit address.
        for (int a = 0; a < 1024; a++) begin
            run_op(0, a, 1'b1);   // set
            run_op(1, a, 1'b0);   // clear
            run_op(2, a, 1'b1);   // carry-AND, bit 0 -> carry cleared
            run_op(3, a, 1'b1);   // carry-AND-inverted, bit 0 -> carry kept
            run_op(0, a, 1'b0);   // set again
            run_op(2, a, 1'b1);   // bit 1 -> carry kept
            run_op(3, a, 1'b1);   // bit 1 -> carry cleared
            run_op(2, a, 1'b0);   // carry 0 stays 0
            run_op(4, a, 1'b1);   // jump: taken, bit cleared
            run_op(4, a, 1'b0);   // jump: not taken, bit stays clear
        end

        // R10: a request held during busy is dropped.
        run_op(1, 77, 1'b0);          // bit 77 is now 0
        eb = exp_byte(77);
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd1; op_hi = 2'd3; op_lo = 8'hF0; // clear 0x3F0
        @(negedge clk);
        op_code = 3'd0; op_hi = 2'd0; op_lo = 8'd77;                  // set 77 while busy
        @(negedge clk);
        op_valid = 1'b0;
        snap = mem[eb];
        chk(done, "R10 first op in result phase", done, 1);
        @(negedge clk);
        chk(!busy, "R10 no second op accepted", busy, 0);
        chk(((mem[eb] >> 5) & 1) == 0, "R10 busy request had no effect", mem[eb], snap);

        // R10: unused codes are not accepted.
        for (int c = 5; c < 8; c++) begin
            @(negedge clk);
            op_valid = 1'b1; op_code = 3'(c); op_hi = 2'd0; op_lo = 8'd9;
            @(negedge clk);
            op_valid = 1'b0;
            chk(!busy && !mem_rd, "R10 unused code ignored", busy, 0);
        end

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule